// File: doc/BRIEF.md
# Power-Aware SMBus Target Address Manager

This block keeps the two target addresses that a storage device presents on its SMBus/I2C management port. Target 0 is a serial-EEPROM style target that serves vital product data. Target 1 is the endpoint of the management transport. For every transaction the address byte seen on the bus is compared with both stored addresses. Each target has its own match flag, so the bit-level bus logic downstream knows which target to acknowledge.

The auxiliary and main supplies together set a power mode:

- **Off:** neither supply is present. Neither target answers.
- **Auxiliary-only:** only the EEPROM target answers.
- **Main-powered:** main power is present, with or without auxiliary power. Both targets answer.

An address resolution agent can move either target to a new address through a one-cycle set command. Each stored address survives only while its target stays powered:

- The EEPROM address set during auxiliary-only operation is kept when main power arrives.
- The EEPROM address falls back to its default once both supplies are gone.
- The endpoint address falls back to its default whenever main power is absent.

Reset stands for the loss of all power. The power flags are taken to be synchronous to `clk`.

Top module: `smbaddr_mgr`

## Requirements
- R1: After reset the EEPROM target address is 7'h53 (bus byte 0xA6 with the R/W bit at 0) and the endpoint address is 7'h6A (bus byte 0xD4); both match outputs are 0 while reset is held.
- R2: A match compares `rx_byte[7:1]` with the stored 7-bit address and ignores `rx_byte[0]` (the R/W bit). The match output is high in the cycle after the clock edge that samples `rx_valid` high with an equal address. It is low after any edge that samples `rx_valid` low.
- R3: In auxiliary-only mode (`aux_pwr`=1, `main_pwr`=0) the EEPROM target matches its address and the endpoint never matches.
- R4: With `main_pwr`=1, both targets match their own addresses, whatever the value of `aux_pwr`.
- R5: With both supplies off, neither target matches.
- R6: A set command (`set_valid`=1; `set_sel`=0 picks the EEPROM target and `set_sel`=1 picks the endpoint; `set_addr` is the new 7-bit address) to a powered target takes effect for transactions sampled at later edges.
- R7: An EEPROM address changed during auxiliary-only mode is kept when main power arrives. It is also kept when main power later leaves while auxiliary power stays.
- R8: Every edge that samples both supplies low returns the EEPROM address to 7'h53. Main power that arrives without prior auxiliary power therefore finds the default.
- R9: Every edge that samples `main_pwr` low returns the endpoint address to 7'h6A.
- R10: A set command to an unpowered target has no effect. This covers the endpoint outside main-powered mode, and either target with both supplies off.
- R11: A transaction sampled at the same edge as a set command is compared with the address held before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (loss of all power) |
| aux_pwr | input | 1 | Auxiliary supply present |
| main_pwr | input | 1 | Main supply present |
| set_valid | input | 1 | Address set command strobe |
| set_sel | input | 1 | Set target: 0 = EEPROM target, 1 = endpoint |
| set_addr | input | 7 | New 7-bit address |
| rx_valid | input | 1 | Address byte of a transaction is valid |
| rx_byte | input | 8 | Transaction address byte, bit 0 = R/W |
| vpd_match | output | 1 | EEPROM target addressed |
| mgmt_match | output | 1 | Endpoint addressed |

## Verification
A match flag is due exactly one edge after its address byte and the power flags are sampled. A change of address or a reversion caused by the power mode shows up on the first transaction sampled at a later edge. The bench drives every input on the falling edge and compares both match flags 1 ns after the next rising edge, against a model that evaluates the transaction with the addresses held before that edge and only then applies the set or revert. Stored addresses are observed only through matches, including the ignored set commands and the addresses that survive a power transition.

// File: rtl/smbaddr_pkg.sv
package smbaddr_pkg;

   typedef enum logic [1:0] {
      PM_OFF  = 2'd0,
      PM_AUX  = 2'd1,
      PM_MAIN = 2'd2
   } pwr_mode_e;

   localparam int unsigned TGT_VPD  = 0;
   localparam int unsigned TGT_MGMT = 1;
   localparam int unsigned NUM_TGT  = 2;

   function automatic pwr_mode_e mode_of(input logic aux, input logic main);
      if (main)
         return PM_MAIN;
      else if (aux)
         return PM_AUX;
      else
         return PM_OFF;
   endfunction

endpackage

// File: rtl/smbaddr_pwr_decode.sv
module smbaddr_pwr_decode
   import smbaddr_pkg::*;
(
   input  logic                aux_pwr,
   input  logic                main_pwr,
   output pwr_mode_e           mode,
   output logic [NUM_TGT-1:0]  powered
);
   always_comb begin
      mode = mode_of(aux_pwr, main_pwr);
      powered = '0;
      unique case (mode)
         PM_AUX:  powered[TGT_VPD] = 1'b1;
         PM_MAIN: powered = '1;
         default: powered = '0;
      endcase
   end
endmodule

// File: rtl/smbaddr_slot.sv
module smbaddr_slot #(
   parameter int unsigned        ADDR_W  = 7,
   parameter logic [ADDR_W-1:0]  DEFAULT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              powered,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= DEFAULT;
      else if (!powered)
         addr_q <= DEFAULT;
      else if (wr)
         addr_q <= wr_addr;
   end

   // R8 / R9 / R10: an unpowered slot sits at its default
   a_r9_unpowered_default: assert property (@(posedge clk) disable iff (!rst_n)
      !powered |=> addr_q == DEFAULT);

   // R6: a write to a powered slot lands
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (powered && wr) |=> addr_q == $past(wr_addr));

   // R7: a powered slot without a write keeps its address
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (powered && !wr) |=> $stable(addr_q));
endmodule

// File: rtl/smbaddr_match.sv
module smbaddr_match #(
   parameter int unsigned ADDR_W     = 7,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [ADDR_W:0]   rx_byte,
   input  logic              enable,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic hit_d;

   always_comb hit_d = rx_valid && enable && (rx_byte[ADDR_W:1] == addr);

   if (REGISTERED) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hit_q <= 1'b0;
         else
            hit_q <= hit_d;
      end
      assign hit = hit_q;

      // R2: no hit without a valid byte
      a_r2_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
         !rx_valid |=> !hit);

      // R3 / R5: an unpowered target stays silent
      a_r5_unpowered_silent: assert property (@(posedge clk) disable iff (!rst_n)
         !enable |=> !hit);

      // R2: the R/W bit has no say in the comparison
      a_r2_rw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_valid && enable && rx_byte[ADDR_W:1] == addr) |=> hit);
   end else begin : g_comb
      assign hit = hit_d;
   end
endmodule

// File: rtl/smbaddr_mgr.sv
module smbaddr_mgr
   import smbaddr_pkg::*;
#(
   parameter int unsigned        ADDR_W           = 7,
   parameter logic [ADDR_W-1:0]  VPD_DEFAULT      = 7'h53,
   parameter logic [ADDR_W-1:0]  MGMT_DEFAULT     = 7'h6A,
   parameter bit                 MATCH_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aux_pwr,
   input  logic              main_pwr,
   input  logic              set_valid,
   input  logic              set_sel,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic              rx_valid,
   input  logic [ADDR_W:0]   rx_byte,
   output logic              vpd_match,
   output logic              mgmt_match
);
   localparam int unsigned BYTE_W = ADDR_W + 1;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_width
      $error("smbaddr_mgr: ADDR_W out of range");
   end
   if (VPD_DEFAULT == MGMT_DEFAULT) begin : g_bad_defaults
      $error("smbaddr_mgr: target defaults must differ");
   end

   pwr_mode_e            mode;
   logic [NUM_TGT-1:0]   powered;
   logic [NUM_TGT-1:0]   hit;
   logic [ADDR_W-1:0]    addr [NUM_TGT];
   logic [BYTE_W-1:0]    rx_b;

   assign rx_b = rx_byte;

   smbaddr_pwr_decode u_pwr (
      .aux_pwr  (aux_pwr),
      .main_pwr (main_pwr),
      .mode     (mode),
      .powered  (powered)
   );

   for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
      localparam logic [ADDR_W-1:0] DEF = (i == TGT_VPD) ? VPD_DEFAULT : MGMT_DEFAULT;
      logic wr;
      assign wr = set_valid && (set_sel == i[0]);

      smbaddr_slot #(.ADDR_W(ADDR_W), .DEFAULT(DEF)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .powered (powered[i]),
         .wr      (wr),
         .wr_addr (set_addr),
         .addr_q  (addr[i])
      );

      smbaddr_match #(.ADDR_W(ADDR_W), .REGISTERED(MATCH_REGISTERED)) u_match (
         .clk      (clk),
         .rst_n    (rst_n),
         .rx_valid (rx_valid),
         .rx_byte  (rx_b),
         .enable   (powered[i]),
         .addr     (addr[i]),
         .hit      (hit[i])
      );
   end

   assign vpd_match  = hit[TGT_VPD];
   assign mgmt_match = hit[TGT_MGMT];

   if (MATCH_REGISTERED) begin : g_top_chk
      // R3: endpoint silent unless main power was present
      a_r3_mgmt_needs_main: assert property (@(posedge clk) disable iff (!rst_n)
         !main_pwr |=> !mgmt_match);
      // R5: nothing answers with both supplies off
      a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (!aux_pwr && !main_pwr) |=> !(vpd_match || mgmt_match));
      // R10: set to unpowered endpoint leaves it at default
      a_r10_mgmt_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (set_valid && set_sel && !main_pwr) |=> addr[TGT_MGMT] == MGMT_DEFAULT);
   end
endmodule

// File: tb/smbaddr_mgr_test.sv
module smbaddr_mgr_test;
   localparam logic [6:0] VPD_DEF  = 7'h53;
   localparam logic [6:0] MGMT_DEF = 7'h6A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       aux_pwr = 1'b0, main_pwr = 1'b0;
   logic       set_valid = 1'b0, set_sel = 1'b0;
   logic [6:0] set_addr = '0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       vpd_match, mgmt_match;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   logic [6:0] m_vpd = VPD_DEF;
   logic [6:0] m_mgmt = MGMT_DEF;

   always #2 clk = ~clk;

   smbaddr_mgr uut (
      .clk(clk), .rst_n(rst_n), .aux_pwr(aux_pwr), .main_pwr(main_pwr),
      .set_valid(set_valid), .set_sel(set_sel), .set_addr(set_addr),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .vpd_match(vpd_match), .mgmt_match(mgmt_match)
   );

   task automatic check(input string tag, input logic av, input logic am,
                        input logic ev, input logic em);
      compared++;
      if (av !== ev || am !== em) begin
         mismatched++;
         $display("FAIL %s: vpd_match/mgmt_match = %b/%b expected %b/%b",
                  tag, av, am, ev, em);
      end
   endtask

   // one transaction cycle: drive at falling edge, check after rising edge
   task automatic step(input string tag, input logic aux, input logic main,
                       input logic sv, input logic sel, input logic [6:0] sa,
                       input logic rv, input logic [7:0] rb);
      logic en_v, en_m, ev, em;
      en_v = aux || main;
      en_m = main;
      ev = rv && en_v && (rb[7:1] == m_vpd);
      em = rv && en_m && (rb[7:1] == m_mgmt);
      if (!en_v) m_vpd = VPD_DEF;
      else if (sv && !sel) m_vpd = sa;
      if (!en_m) m_mgmt = MGMT_DEF;
      else if (sv && sel) m_mgmt = sa;
      @(negedge clk);
      aux_pwr = aux; main_pwr = main;
      set_valid = sv; set_sel = sel; set_addr = sa;
      rx_valid = rv; rx_byte = rb;
      @(posedge clk);
      #1;
      check(tag, vpd_match, mgmt_match, ev, em);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A6D));
      // R1: reset holds both matches low even with a matching byte
      aux_pwr = 1'b1; main_pwr = 1'b1; rx_valid = 1'b1; rx_byte = 8'hA6;
      repeat (3) @(posedge clk);
      #1 check("R1 reset", vpd_match, mgmt_match, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1; rx_valid = 1'b0;

      // R1 / R4 defaults with both supplies
      step("R1 R4 vpd default", 1, 1, 0, 0, 7'h0, 1, 8'hA6);
      step("R1 R4 mgmt default", 1, 1, 0, 0, 7'h0, 1, 8'hD4);
      // R2: R/W bit ignored; idle byte never matches
      step("R2 vpd read bit", 1, 1, 0, 0, 7'h0, 1, 8'hA7);
      step("R2 mgmt read bit", 1, 1, 0, 0, 7'h0, 1, 8'hD5);
      step("R2 no valid", 1, 1, 0, 0, 7'h0, 0, 8'hA6);
      step("R2 other address", 1, 1, 0, 0, 7'h0, 1, 8'hA4);
      // R3: aux only
      step("R3 mgmt silent", 1, 0, 0, 0, 7'h0, 1, 8'hD4);
      step("R3 vpd answers", 1, 0, 0, 0, 7'h0, 1, 8'hA6);
      // R10: endpoint set while unpowered is dropped
      step("R10 mgmt set aux-only", 1, 0, 1, 1, 7'h20, 0, 8'h00);
      step("R10 mgmt kept default", 1, 1, 0, 0, 7'h0, 1, 8'hD4);
      step("R10 mgmt no new addr", 1, 1, 0, 0, 7'h0, 1, 8'h40);
      // R6 / R11: EEPROM set in aux-only, same-cycle byte sees old address
      step("R11 old address", 1, 0, 1, 0, 7'h50, 1, 8'hA6);
      step("R6 new address", 1, 0, 0, 0, 7'h0, 1, 8'hA0);
      step("R6 old gone", 1, 0, 0, 0, 7'h0, 1, 8'hA6);
      // R7: kept across main arrival and departure
      step("R7 main arrives", 1, 1, 0, 0, 7'h0, 1, 8'hA1);
      step("R7 main leaves", 1, 0, 0, 0, 7'h0, 1, 8'hA0);
      // R9: endpoint reverts on main loss
      step("R6 mgmt set", 1, 1, 1, 1, 7'h30, 0, 8'h00);
      step("R6 mgmt new", 1, 1, 0, 0, 7'h0, 1, 8'h60);
      step("R9 main drop", 1, 0, 0, 0, 7'h0, 1, 8'h60);
      step("R9 mgmt default back", 1, 1, 0, 0, 7'h0, 1, 8'hD4);
      step("R9 mgmt old gone", 1, 1, 0, 0, 7'h0, 1, 8'h60);
      // R5 / R8 / R10: all off
      step("R5 off vpd", 0, 0, 0, 0, 7'h0, 1, 8'hA0);
      step("R10 set while off", 0, 0, 1, 0, 7'h11, 1, 8'hA6);
      step("R8 main without aux", 0, 1, 0, 0, 7'h0, 1, 8'hA6);
      step("R8 vpd set gone", 0, 1, 0, 0, 7'h0, 1, 8'h22);

      // constrained random
      begin
         logic aux, main;
         aux = 1'b0; main = 1'b1;
         for (int n = 0; n < 4000; n++) begin
            logic sv, sel, rv;
            logic [6:0] sa;
            logic [7:0] rb;
            int pick;
            string tag;
            if ($urandom_range(15) == 0) aux = ~aux;
            if ($urandom_range(15) == 0) main = ~main;
            sv  = ($urandom_range(7) == 0);
            sel = 1'($urandom_range(1));
            sa  = 7'($urandom_range(127));
            rv  = ($urandom_range(3) != 0);
            pick = $urandom_range(2);
            if (pick == 0)      rb = {m_vpd, 1'($urandom_range(1))};
            else if (pick == 1) rb = {m_mgmt, 1'($urandom_range(1))};
            else                rb = 8'($urandom_range(255));
            if (main)     tag = "R4 R6 R9 random main";
            else if (aux) tag = "R3 R7 R10 random aux";
            else          tag = "R5 R8 random off";
            step(tag, aux, main, sv, sel, sa, rv, rb);
         end
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule